// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a single-clock static RAM model with a four-lane data word. Each lane carries eight data bits and one parity bit, stored as plain data. An access is opened by one of two address strobes: one meant for a processor and one for a cache or bus controller. The strobe loads an address register and resets a two-bit burst counter. Later cycles can step through the aligned four-word block with an advance input. The step order is linear or interleaved, chosen by a static strap input.

Three chip enables gate every strobe. A strobe sampled while the enables do not select the part deselects the device. Writes go either to all lanes through a global write enable or to individual lanes through a byte-write enable and per-lane selects. Read data appears one cycle after the addressing edge. It is flagged by a valid output that an asynchronous, active-low output enable can hold off, except on the first read after the part is selected from the deselected state. A sleep input freezes the block and keeps its contents.

The read port is valid-only, with no back-pressure. The consumer must take `rdata_o` in the cycle in which `rvalid_o` is high, because each result is replaced by the next access. Write data is taken on the edge in which the write is decoded.

Top module: `sram_burst`

## Requirements
- R1: A strobe edge selects the device only if `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0 on that edge. A strobe edge with any other enable value deselects the device. While the device is deselected, no read or write takes place and `rvalid_o` stays 0.
- R2: When both strobes are low on one edge, only `adsp_n_i` acts. `adsp_n_i` is ignored on any edge where `ce1_n_i` is 1.
- R3: A read on edge k shows the word at the accessed address on `rdata_o` after edge k, until edge k+1. `rdata_o` is all zeros whenever `rvalid_o` is 0.
- R4: With `burst_mode_i`=0, the n-th access of a burst (n=0..3 mod 4) uses low address bits (start+n) mod 4. The upper address bits are held.
- R5: With `burst_mode_i`=1, the n-th access uses low address bits start XOR n.
- R6: On an edge with no acting strobe, a selected device advances the burst only if `adv_n_i`=0. Otherwise it repeats the access at the current address.
- R7: `gw_n_i`=0 on an accessing edge writes all four lanes, whatever `bwe_n_i` and `bw_n_i` are. A write edge produces no read result.
- R8: With `gw_n_i`=1 and `bwe_n_i`=0, lane i is written only if `bw_n_i[i]`=0. Lane i is `wdata_i[9i+8:9i]`. With `bwe_n_i`=1 and `gw_n_i`=1, the edge is a read.
- R9: An edge on which `adsp_n_i` acts is always a read, even if write enables are low.
- R10: `oe_n_i` acts without a clock. While it is 1, `rvalid_o` is 0, except in the case R11 allows.
- R11: The result of a read started by a strobe that selects a previously deselected device is flagged valid even if `oe_n_i` is 1.
- R12: While `sleep_i`=1, edges perform no access and change no burst or selection state, and `rvalid_o` is 0 after them. Stored words are kept.
- R13: After reset the device is deselected and `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n_i` sampled on rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr_i | input | ADDR_W | Word address, captured by an acting strobe |
| adsp_n_i | input | 1 | Processor address strobe, active low, higher priority |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable, active low; also gates `adsp_n_i` |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| burst_mode_i | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Sleep, active high |
| wdata_i | input | LANES*LANE_W | Write data, lane i at bits 9i+8:9i |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read result valid |

## Verification
Two things can land on the same edge: a strobe collision and a write request. The bench drives both strobes low together with the global write enable low and fresh write data. It then judges that the edge returned the old stored word and that a later read still finds it unchanged. A second coincidence puts sleep on the same edge as a controller write and a burst advance. The bench checks that neither the word nor the burst position moved, by reading the target word and the next burst step afterwards.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits for burst step 'step' from start value 'start'.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORDER_INTERLEAVE) r = start ^ step;
    else                         r = 2'(start + step);
    return r;
  endfunction

endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  burst_order_e      order_i,
  output logic              acc_valid_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_proc_o,
  output logic              acc_first_o,
  output logic              sel_q_o
);

  localparam int HI_W = ADDR_W - 2;

  logic              sel_q, sel_nx;
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [1:0]        step_q, step_nx;
  logic              p_take, c_take, strobe, ce_ok;

  always_comb begin
    ce_ok   = !ce1_n_i && ce2_i && !ce3_n_i;
    p_take  = !adsp_n_i && !ce1_n_i;
    c_take  = !adsc_n_i && !p_take;
    strobe  = p_take || c_take;

    sel_nx  = strobe ? ce_ok : sel_q;
    base_nx = (strobe && ce_ok) ? addr_i : base_q;
    if (strobe)                   step_nx = 2'd0;
    else if (sel_q && !adv_n_i)   step_nx = 2'(step_q + 2'd1);
    else                          step_nx = step_q;

    acc_valid_o = !sleep_i && sel_nx;
    acc_addr_o  = {base_nx[ADDR_W-1 -: HI_W], burst_lo(base_nx[1:0], step_nx, order_i)};
    acc_proc_o  = p_take;
    acc_first_o = strobe && ce_ok && !sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      base_q <= '0;
      step_q <= 2'd0;
    end else if (!sleep_i) begin
      sel_q  <= sel_nx;
      base_q <= base_nx;
      step_q <= step_nx;
    end
  end

  assign sel_q_o = sel_q;

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic                    re_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    rd_q        <= mem[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sram_read_port.sv
module sram_read_port #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire_i,
  input  logic              rd_first_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic pend_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      pend_q <= rd_fire_i;
      mask_q <= rd_fire_i && rd_first_i;
    end
  end

  always_comb begin
    rvalid_o = pend_q && (mask_q || !oe_n_i);
    rdata_o  = rvalid_o ? word_i : '0;
  end

endmodule

// File: rtl/sram_burst.sv
module sram_burst
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_n_i,
  input  logic                    adsc_n_i,
  input  logic                    adv_n_i,
  input  logic                    ce1_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    gw_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        bw_n_i,
  input  logic                    oe_n_i,
  input  logic                    burst_mode_i,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              acc_valid, acc_proc, acc_first, sel_q;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              is_write, rd_fire;
  logic [DATA_W-1:0] word;

  sram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .addr_i      (addr_i),
    .adsp_n_i    (adsp_n_i),
    .adsc_n_i    (adsc_n_i),
    .adv_n_i     (adv_n_i),
    .ce1_n_i     (ce1_n_i),
    .ce2_i       (ce2_i),
    .ce3_n_i     (ce3_n_i),
    .order_i     (burst_order_e'(burst_mode_i)),
    .acc_valid_o (acc_valid),
    .acc_addr_o  (acc_addr),
    .acc_proc_o  (acc_proc),
    .acc_first_o (acc_first),
    .sel_q_o     (sel_q)
  );

  // Global write covers every lane; byte write needs its enable plus the lane select.
  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign lane_we[g] = acc_valid && !acc_proc && (!gw_n_i || (!bwe_n_i && !bw_n_i[g]));
  end

  assign is_write = |lane_we;
  assign rd_fire  = acc_valid && !is_write;

  sram_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .addr_i  (acc_addr),
    .we_i    (lane_we),
    .re_i    (rd_fire),
    .wdata_i (wdata_i),
    .rdata_o (word)
  );

  sram_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire_i  (rd_fire),
    .rd_first_i (acc_first),
    .oe_n_i     (oe_n_i),
    .word_i     (word),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adsp_n_i,
  input logic              adsc_n_i,
  input logic              ce1_n_i,
  input logic              ce2_i,
  input logic              ce3_n_i,
  input logic              oe_n_i,
  input logic              sleep_i,
  input logic              sel_q_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o
);

  logic ce_ok, any_strobe;
  assign ce_ok      = !ce1_n_i && ce2_i && !ce3_n_i;
  assign any_strobe = (!adsp_n_i && !ce1_n_i) || !adsc_n_i;

  AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && any_strobe && !ce_ok) |=> !rvalid_o);  // R1

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |-> (rdata_o == '0));  // R3

  AST_PROC_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !adsp_n_i && ce_ok) |=> (rvalid_o || oe_n_i));  // R9

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && sel_q_i && !adsp_n_i && ce_ok) |=> (rvalid_o == !oe_n_i));  // R10

  AST_FIRST_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !sel_q_i && !adsp_n_i && ce_ok) |=> rvalid_o);  // R11

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !rvalid_o);  // R12

endmodule

bind sram_burst sram_burst_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adsp_n_i (adsp_n_i),
  .adsc_n_i (adsc_n_i),
  .ce1_n_i  (ce1_n_i),
  .ce2_i    (ce2_i),
  .ce3_n_i  (ce3_n_i),
  .oe_n_i   (oe_n_i),
  .sleep_i  (sleep_i),
  .sel_q_i  (sel_q),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o)
);

// File: tb/sram_burst_tb.sv
`timescale 1ns/1ps
module sram_burst_tb;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, mode, sleep;
  logic [NL-1:0] bw_n;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  sram_burst u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .burst_mode_i(mode),
    .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // mode, hi(4), start(2), four expected low-bit values
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 4'd1, 2'd0, 8'b00_01_10_11},
    {1'b0, 4'd2, 2'd1, 8'b01_10_11_00},
    {1'b0, 4'd3, 2'd2, 8'b10_11_00_01},
    {1'b0, 4'd4, 2'd3, 8'b11_00_01_10},
    {1'b1, 4'd5, 2'd0, 8'b00_01_10_11},
    {1'b1, 4'd6, 2'd1, 8'b01_00_11_10},
    {1'b1, 4'd7, 2'd2, 8'b10_11_00_01},
    {1'b1, 4'd8, 2'd3, 8'b11_10_01_00}
  };

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) * 36'h0_0123_4567 + 36'h9_0000_0011;
  endfunction

  task automatic idle();
    addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; sleep = 0; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic v_exp, input logic [DW-1:0] d_exp);
    checks++;
    if (rvalid !== v_exp || rdata !== d_exp) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", tag, rvalid, rdata, v_exp, d_exp);
    end
  endtask

  task automatic ctrl_read(input logic [AW-1:0] a);
    idle(); adsc_n = 0; addr = a; tick();
  endtask

  task automatic merge(input logic [AW-1:0] a, input logic [NL-1:0] lanes, input logic [DW-1:0] d);
    for (int i = 0; i < NL; i++)
      if (lanes[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); oe_n = 0; mode = 0;
    repeat (3) tick();
    chk("R13 reset idle", 1'b0, '0);
    rst_n = 1; tick();
    chk("R13 deselected after reset", 1'b0, '0);

    // Fill every word with a global write
    for (int a = 0; a < DEPTH; a++) begin
      idle(); adsc_n = 0; addr = AW'(a); gw_n = 0; wdata = pat(a); tick();
      ref_mem[a] = pat(a);
    end

    // Burst order table
    for (int k = 0; k < 8; k++) begin
      logic [14:0] v;
      logic [AW-1:0] hi_a;
      string tag;
      v = VEC[k];
      tag = v[14] ? "R5 interleaved" : "R4 linear";
      mode = v[14];
      idle(); adsp_n = 0; addr = {v[13:10], v[9:8]}; tick();
      hi_a = {v[13:10], 2'b00};
      chk(tag, 1'b1, ref_mem[hi_a | AW'(v[7:6])]);
      for (int s = 1; s < 4; s++) begin
        idle(); adv_n = 0; tick();
        chk(tag, 1'b1, ref_mem[hi_a | AW'(v[7 - 2*s -: 2])]);
      end
    end
    mode = 0;

    // R6 hold without advance
    idle(); adsp_n = 0; addr = 6'd40; tick();
    chk("R3 read latency", 1'b1, ref_mem[40]);
    idle(); tick();
    chk("R6 hold address", 1'b1, ref_mem[40]);

    // R2/R9 strobe collision with write request
    idle(); adsp_n = 0; adsc_n = 0; addr = 6'd44; gw_n = 0; wdata = '1; tick();
    chk("R2 processor strobe wins", 1'b1, ref_mem[44]);
    ctrl_read(6'd44);
    chk("R9 no write on processor strobe", 1'b1, ref_mem[44]);

    // R2 processor strobe ignored when ce1 high
    idle(); adsp_n = 0; ce1_n = 1; addr = 6'd50; tick();
    chk("R2 strobe ignored ce1 high", 1'b1, ref_mem[44]);

    // R1 deselect via controller strobe with ce1 high
    idle(); adsp_n = 0; ce1_n = 1; adsc_n = 0; addr = 6'd50; tick();
    chk("R1 deselect", 1'b0, '0);
    idle(); adv_n = 0; gw_n = 0; wdata = '1; tick();
    chk("R1 no access while deselected", 1'b0, '0);

    // R11 first read after deselect ignores oe
    oe_n = 1;
    idle(); adsp_n = 0; addr = 6'd48; tick();
    chk("R11 first read shown", 1'b1, ref_mem[48]);
    idle(); adv_n = 0; tick();
    chk("R10 oe high hides", 1'b0, '0);
    oe_n = 0; #1;
    chk("R10 oe acts without clock", 1'b1, ref_mem[49]);
    oe_n = 1;
    idle(); adsp_n = 0; addr = 6'd45; tick();
    chk("R10 selected read hidden", 1'b0, '0);
    oe_n = 0; #1;
    chk("R1 deselected write missed", 1'b1, ref_mem[45]);

    // R7 / R8 writes
    idle(); adsc_n = 0; addr = 6'd20; gw_n = 0; wdata = 36'h1_2345_6789; tick();
    ref_mem[20] = 36'h1_2345_6789;
    chk("R7 write gives no result", 1'b0, '0);
    ctrl_read(6'd20);
    chk("R7 global write", 1'b1, ref_mem[20]);
    idle(); adsc_n = 0; addr = 6'd20; bwe_n = 0; bw_n = 4'b1010; wdata = 36'hF_EDCB_A987; tick();
    merge(6'd20, 4'b0101, 36'hF_EDCB_A987);
    ctrl_read(6'd20);
    chk("R8 lanes 0 and 2", 1'b1, ref_mem[20]);
    idle(); adsc_n = 0; addr = 6'd20; bw_n = 4'b0000; wdata = 36'h0_0000_0000; tick();
    chk("R8 no byte enable reads", 1'b1, ref_mem[20]);
    idle(); adsc_n = 0; addr = 6'd21; gw_n = 0; bwe_n = 0; bw_n = 4'b1110; wdata = 36'hA_5A5A_5A5A; tick();
    ref_mem[21] = 36'hA_5A5A_5A5A;
    ctrl_read(6'd21);
    chk("R7 global overrides byte", 1'b1, ref_mem[21]);

    // R12 sleep coincides with write and advance
    idle(); adsp_n = 0; addr = 6'd24; tick();
    chk("R12 setup", 1'b1, ref_mem[24]);
    idle(); sleep = 1; adsc_n = 0; addr = 6'd20; gw_n = 0; adv_n = 0; wdata = '0; tick();
    chk("R12 sleep no result", 1'b0, '0);
    idle(); adv_n = 0; tick();
    chk("R12 burst held", 1'b1, ref_mem[25]);
    ctrl_read(6'd20);
    chk("R12 contents kept", 1'b1, ref_mem[20]);

    // Write during burst advance
    idle(); adsp_n = 0; addr = 6'd28; tick();
    idle(); adv_n = 0; gw_n = 0; wdata = 36'h3_3333_3333; tick();
    ref_mem[29] = 36'h3_3333_3333;
    chk("R7 burst write", 1'b0, '0);
    ctrl_read(6'd29);
    chk("R4 burst write address", 1'b1, ref_mem[29]);

    // R1 via ce3
    idle(); adsc_n = 0; ce3_n = 1; addr = 6'd30; tick();
    chk("R1 ce3 deselect", 1'b0, '0);

    // R13 reset mid-run
    ctrl_read(6'd31);
    rst_n = 0; #1;
    chk("R13 reset clears", 1'b0, '0);
    tick(); rst_n = 1;
    idle(); adv_n = 0; tick();
    chk("R13 deselected after reset", 1'b0, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule